// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Level Prescaler

This block produces the common time base shared by the two outputs of a PWM unit. The input clock first passes through a two-stage divider. Its factor is a power of two times an even multiplier. Each divided tick advances a 16-bit counter, which runs against a single period value that both output channels share. The counter can count up, count down, count up and down, or hold still. The period value can be changed at once, or it can be staged and applied when the counter next reaches zero. That staging lets a period change land cleanly on a cycle boundary.

Downstream compare and output logic reads the current count and direction. It also receives two single-cycle strobes, one for reaching zero and one for reaching the period. A small write port sets the control word and the period. The block has no read path and no interrupt logic.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is low and after it is released, the count is 0, the direction is up, both strobes are low, and the control word is in hold mode (mode 11) with shadow loading and both divider codes at 0.
- R2: The counter steps once every F input clock cycles. F = (1 << C) * (H == 0 ? 1 : 2*H), where C is the slow divider code at control bits 12:10 and H is the fast divider code at control bits 9:7. `tick` marks each cycle in which a step is due.
- R3: A control write that changes C or H restarts the divider phase. The next step then comes F cycles after the write edge.
- R4: Mode 00 (up): the count rises by one per step from 0 to the period. The step after the period, or any count above it, gives 0.
- R5: Mode 01 (down): the count falls by one per step. A step taken at 0 reloads the period.
- R6: Mode 10 (up-down): the counter turns to falling when a step is taken at or above the period, and turns to rising when a step is taken at 0. `dir_down` is 1 while falling. Modes 00 and 01 report 0 and 1 after their first step.
- R7: Mode 11 (hold): the count and direction do not change and no strobe fires.
- R8: `zero_evt` is high for exactly the cycle in which a step has just set the count to 0.
- R9: `prd_evt` is high for exactly the cycle in which a step has just set the count equal to the period that was active before that step.
- R10: Control bit 3 = 0 (shadow): a period write only updates the staged value. The staged value becomes active on the step that sets the count to 0.
- R11: Control bit 3 = 1 (immediate): a period write updates the active period at the write edge.
- R12: `wr_sel` = 0 writes the control word (mode in bits 1:0, load select in bit 3, H in 9:7, C in 12:10). `wr_sel` = 1 writes the period. All other control bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = control word, 1 = period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | 1 while the counter is falling |
| zero_evt | output | 1 | Zero-reached strobe |
| prd_evt | output | 1 | Period-reached strobe |
| tick | output | 1 | Step due in this cycle |

## Verification
The bench probes these corners:
- A period of 0 in up-down mode must keep the count at 0, with both strobes firing on every step. A wrong turn-around rule would let the count escape to 1 or to 0xFFFF.
- A divider change part way through a phase must restart the phase. A design that keeps the old phase count can run past the new terminal value and stall for thousands of cycles.
- A staged period must not take effect until zero is reached. A design that loads it early cuts the running cycle short.
- An immediate period write must let the count climb past the old period in the same cycle. A design that treats every write as staged would wrap at the old value.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  typedef enum logic [1:0] {
    CNT_UP     = 2'b00,
    CNT_DOWN   = 2'b01,
    CNT_UPDOWN = 2'b10,
    CNT_HOLD   = 2'b11
  } cnt_mode_e;

  // Control word field positions (decoded by the register slice)
  localparam int MODE_LSB = 0;
  localparam int LOAD_BIT = 3;
  localparam int FAST_LSB = 7;
endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
  parameter int CODE_W = 3,
  parameter int FACT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] slow_code,
  input  logic [CODE_W-1:0] fast_code,
  input  logic              restart,
  output logic              tick,
  output logic [FACT_W-1:0] factor
);
  logic [FACT_W-1:0] fast_mul;
  logic [FACT_W-1:0] phase_q, phase_d;

  always_comb begin
    fast_mul = (fast_code == '0) ? FACT_W'(1) : FACT_W'({fast_code, 1'b0});
    factor   = fast_mul << slow_code;
    tick     = (phase_q == factor - FACT_W'(1));
    if (restart || tick) phase_d = '0;
    else                 phase_d = phase_q + FACT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              zero_load,
  output cnt_mode_e         mode,
  output logic [CODE_W-1:0] slow_code,
  output logic [CODE_W-1:0] fast_code,
  output logic              div_restart,
  output logic [CNT_W-1:0]  prd_active
);
  localparam int SLOW_LSB = FAST_LSB + CODE_W;

  logic              ctrl_wr, prd_wr, imm_q, imm_d;
  cnt_mode_e         mode_d;
  logic [CODE_W-1:0] slow_d, fast_d, new_slow, new_fast;
  logic [CNT_W-1:0]  shadow_q, shadow_d, active_d;

  always_comb begin
    ctrl_wr     = wr_en && !wr_sel;
    prd_wr      = wr_en && wr_sel;
    new_slow    = wr_data[SLOW_LSB +: CODE_W];
    new_fast    = wr_data[FAST_LSB +: CODE_W];
    div_restart = ctrl_wr && ((new_slow != slow_code) || (new_fast != fast_code));
    mode_d   = mode;
    imm_d    = imm_q;
    slow_d   = slow_code;
    fast_d   = fast_code;
    if (ctrl_wr) begin
      mode_d = cnt_mode_e'(wr_data[MODE_LSB +: 2]);
      imm_d  = wr_data[LOAD_BIT];
      slow_d = new_slow;
      fast_d = new_fast;
    end
    shadow_d = prd_wr ? wr_data : shadow_q;
    active_d = prd_active;
    if (prd_wr && (imm_q || zero_load)) active_d = wr_data;
    else if (zero_load)                 active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= CNT_HOLD;
      imm_q      <= 1'b0;
      slow_code  <= '0;
      fast_code  <= '0;
      shadow_q   <= '0;
      prd_active <= '0;
    end else begin
      mode       <= mode_d;
      imm_q      <= imm_d;
      slow_code  <= slow_d;
      fast_code  <= fast_d;
      shadow_q   <= shadow_d;
      prd_active <= active_d;
    end
  end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             zero_evt,
  output logic             prd_evt,
  output logic             zero_load
);
  logic             advance, dir_d, zero_d, prd_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    advance = tick && (mode != CNT_HOLD);
    cnt_d   = count;
    dir_d   = dir_down;
    if (advance) begin
      case (mode)
        CNT_UP: begin
          dir_d = 1'b0;
          cnt_d = (count >= prd) ? '0 : count + CNT_W'(1);
        end
        CNT_DOWN: begin
          dir_d = 1'b1;
          cnt_d = (count == '0) ? prd : count - CNT_W'(1);
        end
        CNT_UPDOWN: begin
          if (!dir_down) begin
            if (count >= prd) begin
              dir_d = 1'b1;
              cnt_d = (count == '0) ? '0 : count - CNT_W'(1);
            end else begin
              cnt_d = count + CNT_W'(1);
            end
          end else begin
            if (count == '0) begin
              dir_d = 1'b0;
              cnt_d = (prd == '0) ? '0 : CNT_W'(1);
            end else begin
              cnt_d = count - CNT_W'(1);
            end
          end
        end
        default: cnt_d = count;
      endcase
    end
    zero_d    = advance && (cnt_d == '0);
    prd_d     = advance && (cnt_d == prd);
    zero_load = zero_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
    end else begin
      count    <= cnt_d;
      dir_down <= dir_d;
      zero_evt <= zero_d;
      prd_evt  <= prd_d;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             zero_evt,
  output logic             prd_evt,
  output logic             tick
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int FACT_W   = MAX_CODE + $clog2(2 * MAX_CODE + 1);

  cnt_mode_e         mode;
  logic [CODE_W-1:0] slow_code, fast_code;
  logic              div_restart, zero_load;
  logic [CNT_W-1:0]  prd_active;
  logic [FACT_W-1:0] factor;

  pwm_tb_regs #(.CNT_W(CNT_W), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .zero_load(zero_load), .mode(mode), .slow_code(slow_code), .fast_code(fast_code),
    .div_restart(div_restart), .prd_active(prd_active)
  );

  pwm_tb_prescale #(.CODE_W(CODE_W), .FACT_W(FACT_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .slow_code(slow_code), .fast_code(fast_code),
    .restart(div_restart), .tick(tick), .factor(factor)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .prd(prd_active),
    .count(count), .dir_down(dir_down), .zero_evt(zero_evt), .prd_evt(prd_evt),
    .zero_load(zero_load)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FACT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input cnt_mode_e         mode,
  input logic [CNT_W-1:0]  count,
  input logic              zero_evt,
  input logic              prd_evt,
  input logic [CNT_W-1:0]  prd_active,
  input logic [FACT_W-1:0] factor
);
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || factor == FACT_W'(1)));
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CNT_UP && count < prd_active) |=> count == CNT_W'($past(count) + 1));
  p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CNT_DOWN && count != '0) |=> count == CNT_W'($past(count) - 1));
  p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CNT_HOLD) |=> $stable(count));
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CNT_HOLD) |=> (!zero_evt && !prd_evt));
  p_zero_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> count == '0);
  p_prd_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prd_evt |-> count == $past(prd_active));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W), .FACT_W(FACT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .count(count),
  .zero_evt(zero_evt), .prd_evt(prd_evt), .prd_active(prd_active), .factor(factor)
);

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen = 1'b0, wsel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] count;
  logic        dir_down, zero_evt, prd_evt, tick;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wen), .wr_sel(wsel), .wr_data(wdata),
    .count(count), .dir_down(dir_down), .zero_evt(zero_evt), .prd_evt(prd_evt), .tick(tick)
  );

  // Reference state, written from the requirements
  int m_mode, m_imm, m_slow, m_fast, m_shadow, m_active, m_cnt, m_dir, m_zero, m_prd, m_phase;

  // {ctrl, period, cycles}
  localparam logic [63:0] VEC [9] = '{
    {16'h0008, 16'd5, 32'd40},   // up, immediate, F=1
    {16'h0009, 16'd4, 32'd40},   // down
    {16'h000A, 16'd3, 32'd40},   // up-down
    {16'h0080, 16'd2, 32'd60},   // up, shadow, F=2
    {16'h0501, 16'd3, 32'd120},  // down, F=8
    {16'h0802, 16'd0, 32'd60},   // up-down, shadow, period 0, F=4
    {16'hC008, 16'd7, 32'd30},   // up with ignored control bits set
    {16'h0003, 16'd9, 32'd30},   // hold
    {16'h038A, 16'd2, 32'd120}   // up-down, F=14
  };

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fac_of(int s, int f);
    return ((f == 0) ? 1 : 2 * f) << s;
  endfunction

  task automatic model_reset();
    m_mode = 3; m_imm = 0; m_slow = 0; m_fast = 0; m_shadow = 0; m_active = 0;
    m_cnt = 0; m_dir = 0; m_zero = 0; m_prd = 0; m_phase = 0;
  endtask

  task automatic model_edge();
    int fac, nc, nd, ns, nf;
    bit tk, adv;
    fac = fac_of(m_slow, m_fast);
    tk  = (m_phase == fac - 1);
    adv = tk && (m_mode != 3);
    nc = m_cnt; nd = m_dir;
    if (adv) begin
      if (m_mode == 0) begin nd = 0; nc = (m_cnt >= m_active) ? 0 : m_cnt + 1; end
      else if (m_mode == 1) begin nd = 1; nc = (m_cnt == 0) ? m_active : m_cnt - 1; end
      else if (m_dir == 0) begin
        if (m_cnt >= m_active) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else nc = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin nd = 0; nc = (m_active == 0) ? 0 : 1; end
        else nc = m_cnt - 1;
      end
    end
    m_zero = adv && (nc == 0);
    m_prd  = adv && (nc == m_active);
    if (wen && wsel) begin
      m_shadow = wdata;
      if (m_imm != 0 || m_zero != 0) m_active = wdata;
    end else if (m_zero != 0) m_active = m_shadow;
    ns = int'(wdata[12:10]); nf = int'(wdata[9:7]);
    if (wen && !wsel && (ns != m_slow || nf != m_fast)) m_phase = 0;
    else if (tk) m_phase = 0;
    else m_phase = m_phase + 1;
    if (wen && !wsel) begin
      m_mode = int'(wdata[1:0]); m_imm = int'(wdata[3]); m_slow = ns; m_fast = nf;
    end
    m_cnt = nc; m_dir = nd;
  endtask

  task automatic step();
    string ctag;
    @(posedge clk); #1;
    model_edge();
    case (m_mode)
      0: ctag = "R4"; 1: ctag = "R5"; 2: ctag = "R6"; default: ctag = "R7";
    endcase
    chk(ctag, int'(count), m_cnt);
    chk("R6 dir", int'(dir_down), m_dir);
    chk("R8", int'(zero_evt), m_zero);
    chk("R9", int'(prd_evt), m_prd);
    chk("R2 tick", int'(tick), int'(m_phase == fac_of(m_slow, m_fast) - 1));
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    wen = 1'b1; wsel = sel; wdata = d;
    step();
    wen = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int seen, gap, maxc;
    int last;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count in reset", int'(count), 0);
    chk("R1 zero in reset", int'(zero_evt), 0);
    rst_n = 1'b1;
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dir_down), 0);
    chk("R1 prd", int'(prd_evt), 0);
    repeat (6) step();
    chk("R1 R7 hold after reset", int'(count), 0);

    // Table of vectors (R12 field map)
    foreach (VEC[i]) begin
      wr(1'b1, VEC[i][47:32]);
      wr(1'b0, VEC[i][63:48]);
      repeat (int'(VEC[i][31:0])) step();
    end

    // R4 literal sequence with period 2
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'd2);
    seen = 0;
    for (int k = 0; k < 8 && seen == 0; k++) begin step(); if (count == 0) seen = 1; end
    chk("R4 reached zero", seen, 1);
    step(); chk("R4 first", int'(count), 1);
    step(); chk("R4 top", int'(count), 2); chk("R9 top strobe", int'(prd_evt), 1);
    step(); chk("R4 wrap", int'(count), 0); chk("R8 wrap strobe", int'(zero_evt), 1);

    // R2 spacing with F = 4*6 = 24
    wr(1'b1, 16'd100);
    wr(1'b0, 16'h0988);
    last = int'(count);
    for (int k = 0; k < 60 && int'(count) == last; k++) step();
    last = int'(count); gap = 0;
    for (int k = 0; k < 60 && int'(count) == last; k++) begin step(); gap++; end
    chk("R2 gap F=24", gap, 24);

    // R3 restart: change to F = 2*6 = 12 mid-phase
    repeat (10) step();
    last = int'(count);
    wr(1'b0, 16'h0588);
    gap = 0;
    for (int k = 0; k < 100 && int'(count) == last; k++) begin step(); gap++; end
    chk("R3 first step after restart", gap, 12);

    // R10 shadow load
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd3);
    maxc = 0;
    for (int k = 0; k < 20; k++) begin step(); if (int'(count) > maxc) maxc = int'(count); end
    chk("R10 staged value not yet active", int'(maxc > 3), 1);
    seen = 0;
    for (int k = 0; k < 200 && seen == 0; k++) begin step(); if (zero_evt) seen = 1; end
    chk("R10 zero reached", seen, 1);
    step(); chk("R10 after load 1", int'(count), 1);
    step(); step(); chk("R10 new period", int'(count), 3);
    step(); chk("R10 wrap at new period", int'(count), 0);

    // R11 immediate load
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'd5);
    seen = 0;
    for (int k = 0; k < 20 && seen == 0; k++) begin step(); if (count == 4) seen = 1; end
    chk("R11 reached 4", seen, 1);
    wen = 1'b1; wsel = 1'b1; wdata = 16'd7;
    step(); wen = 1'b0;
    chk("R11 past old", int'(count), 5);
    step(); step(); chk("R11 new top", int'(count), 7); chk("R11 R9 strobe", int'(prd_evt), 1);
    step(); chk("R11 wrap", int'(count), 0);

    // Reset during operation
    rst_n = 1'b0; #1;
    model_reset();
    chk("R1 async clear", int'(count), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) step();

    done = 1;
    summary();
    $finish;
  end
endmodule